// File: doc/BRIEF.md
# Serial Receive Word Match Detector

This block sits next to the receive shifter of a serial peripheral interface and watches each data word as it arrives within a frame. A 3-bit mode selector chooses the rule. Each rule compares words against two reference values, called reference A and reference B. A rule can test only the opening word of a frame or every word. It can look for a single word equal to either reference. It can look for an ordered pair of words, A followed by B. It can also test a single word against A under a bit mask taken from reference B.

A word arrives as a one-cycle valid strobe with its data. The frame-start qualifier is raised together with the strobe of the first word after chip select asserts. A successful rule produces a registered one-cycle hit pulse. The pulse also sets a sticky flag, which software clears through a write-one-to-clear input. Shifting, storage and any action taken on a hit belong to neighbouring blocks.

Top module: `rx_word_matcher`

## Requirements
- R1: After reset, `hit_pulse` and `hit_flag` are 0, and no frame is open: a word without `frame_sof` never counts as the opening word.
- R2: Modes 3'b000 and 3'b001 never produce a hit, whatever the words are.
- R3: In mode 3'b010, a hit occurs when the opening word of a frame equals reference A or reference B. Later words never hit.
- R4: In mode 3'b011, a hit occurs for every word of the frame that equals reference A or reference B.
- R5: In mode 3'b100, a hit occurs on the second word of a frame when the opening word equals A and the second word equals B.
- R6: In mode 3'b101, a hit occurs on any word equal to B whose immediate predecessor in the same frame equals A. Every word equal to A re-arms the rule, and any other word disarms it.
- R7: In mode 3'b110, a hit occurs when (opening word AND B) equals (A AND B).
- R8: In mode 3'b111, the masked test of R7 is applied to every word of the frame.
- R9: A word carrying `frame_sof` restarts the word position count and discards any pending A from the previous frame.
- R10: `hit_pulse` is high for exactly the one clock cycle that follows the edge sampling the hitting word, and it is low at all other times.
- R11: `hit_flag` rises on the edge after `hit_pulse` is high and then stays high. It falls on the edge where `flag_clr` is high and `hit_pulse` is low. When `flag_clr` and `hit_pulse` are both high, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | One-cycle strobe: a received word is on `word_data` |
| frame_sof | input | 1 | With `word_vld`: this word opens a new frame |
| word_data | input | DATA_W | Received word |
| match_mode | input | 3 | Rule selector (encodings in R2 to R8) |
| ref_a | input | DATA_W | Reference A |
| ref_b | input | DATA_W | Reference B, also used as the mask in the masked modes |
| flag_clr | input | 1 | Write-one-to-clear for the sticky flag |
| hit_pulse | output | 1 | One-cycle hit indication |
| hit_flag | output | 1 | Sticky hit flag |

## Verification
A word strobed at one clock edge yields its hit pulse in the cycle right after that edge. The sticky flag follows one edge later again. A clear takes effect on the edge that samples it. The driver pushes one expected entry per cycle it drives, holding both the pulse and the flag value predicted by the rules. The monitor pops one entry a short time after each following edge, so each prediction is compared exactly when the registered outputs have settled. Idle cycles are checked like words, which shows that a pulse never lasts longer than one cycle.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

   typedef enum logic [2:0] {
      MM_OFF          = 3'b000,
      MM_RSVD         = 3'b001,
      MM_FIRST_EITHER = 3'b010,
      MM_ANY_EITHER   = 3'b011,
      MM_FIRST_PAIR   = 3'b100,
      MM_ANY_PAIR     = 3'b101,
      MM_FIRST_MASKED = 3'b110,
      MM_ANY_MASKED   = 3'b111
   } mm_mode_e;

   typedef struct packed {
      logic eq_a;
      logic eq_b;
      logic eq_masked;
   } cmp_hits_t;

endpackage

// File: rtl/rxm_compare.sv
module rxm_compare #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]  word_i,
   input  logic [DATA_W-1:0]  ref_a_i,
   input  logic [DATA_W-1:0]  ref_b_i,
   output rxm_pkg::cmp_hits_t hits_o
);

   logic [DATA_W-1:0] diff_a;
   logic [DATA_W-1:0] diff_b;
   logic [DATA_W-1:0] diff_m;

   generate
      for (genvar g = 0; g < DATA_W; g++) begin : g_bit
         assign diff_a[g] = word_i[g] ^ ref_a_i[g];
         assign diff_b[g] = word_i[g] ^ ref_b_i[g];
         // a bit only matters where the mask (reference B) is one
         assign diff_m[g] = diff_a[g] & ref_b_i[g];
      end
   endgenerate

   always_comb begin
      hits_o.eq_a      = ~|diff_a;
      hits_o.eq_b      = ~|diff_b;
      hits_o.eq_masked = ~|diff_m;
   end

endmodule

// File: rtl/rxm_position.sv
module rxm_position #(
   parameter int IDX_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic word_vld_i,
   input  logic frame_sof_i,
   output logic is_first_o,
   output logic is_second_o
);

   localparam logic [IDX_W-1:0] IDX_CAP = IDX_W'(2);

   generate
      if (IDX_W < 2) begin : g_bad_idx
         $error("rxm_position: IDX_W must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_cur;

   // no frame is open out of reset: the count starts saturated
   assign idx_cur     = frame_sof_i ? '0 : idx_q;
   assign is_first_o  = (idx_cur == '0);
   assign is_second_o = (idx_cur == IDX_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= IDX_CAP;
      end else if (word_vld_i) begin
         idx_q <= (idx_cur >= IDX_CAP) ? IDX_CAP : idx_cur + IDX_W'(1);
      end
   end

endmodule

// File: rtl/rxm_rule.sv
module rxm_rule (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_vld_i,
   input  logic               frame_sof_i,
   input  logic               is_first_i,
   input  logic               is_second_i,
   input  rxm_pkg::cmp_hits_t hits_i,
   input  logic [2:0]         mode_i,
   output logic               hit_o
);
   import rxm_pkg::*;

   mm_mode_e mode;
   logic     first_was_a_q;
   logic     armed_q;
   logic     armed_cur;
   logic     rule_hit;

   assign mode      = mm_mode_e'(mode_i);
   assign armed_cur = armed_q & ~frame_sof_i;

   always_comb begin
      unique case (mode)
         MM_FIRST_EITHER: rule_hit = is_first_i & (hits_i.eq_a | hits_i.eq_b);
         MM_ANY_EITHER:   rule_hit = hits_i.eq_a | hits_i.eq_b;
         MM_FIRST_PAIR:   rule_hit = is_second_i & first_was_a_q & hits_i.eq_b;
         MM_ANY_PAIR:     rule_hit = armed_cur & hits_i.eq_b;
         MM_FIRST_MASKED: rule_hit = is_first_i & hits_i.eq_masked;
         MM_ANY_MASKED:   rule_hit = hits_i.eq_masked;
         default:         rule_hit = 1'b0;
      endcase
   end

   assign hit_o = word_vld_i & rule_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_was_a_q <= 1'b0;
         armed_q       <= 1'b0;
      end else if (word_vld_i) begin
         armed_q <= hits_i.eq_a;
         if (is_first_i) begin
            first_was_a_q <= hits_i.eq_a;
         end
      end
   end

endmodule

// File: rtl/rxm_flag.sv
module rxm_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic clr_i,
   output logic pulse_o,
   output logic flag_o
);

   logic pulse_q;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= hit_i;
   end

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= pulse_q | (flag_q & ~clr_i);
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= ~clr_i & (pulse_q | flag_q);
         end
      end
   endgenerate

   assign pulse_o = pulse_q;
   assign flag_o  = flag_q;

endmodule

// File: rtl/rx_word_matcher.sv
module rx_word_matcher #(
   parameter int DATA_W   = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld,
   input  logic              frame_sof,
   input  logic [DATA_W-1:0] word_data,
   input  logic [2:0]        match_mode,
   input  logic [DATA_W-1:0] ref_a,
   input  logic [DATA_W-1:0] ref_b,
   input  logic              flag_clr,
   output logic              hit_pulse,
   output logic              hit_flag
);

   localparam int IDX_W = 2;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_word_matcher: DATA_W must be positive");
      end
   endgenerate

   rxm_pkg::cmp_hits_t hits;
   logic               is_first;
   logic               is_second;
   logic               hit_now;

   rxm_compare #(.DATA_W(DATA_W)) i_compare (
      .word_i  (word_data),
      .ref_a_i (ref_a),
      .ref_b_i (ref_b),
      .hits_o  (hits)
   );

   rxm_position #(.IDX_W(IDX_W)) i_position (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_vld_i  (word_vld),
      .frame_sof_i (frame_sof),
      .is_first_o  (is_first),
      .is_second_o (is_second)
   );

   rxm_rule i_rule (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_vld_i  (word_vld),
      .frame_sof_i (frame_sof),
      .is_first_i  (is_first),
      .is_second_i (is_second),
      .hits_i      (hits),
      .mode_i      (match_mode),
      .hit_o       (hit_now)
   );

   rxm_flag #(.SET_WINS(SET_WINS)) i_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_now),
      .clr_i   (flag_clr),
      .pulse_o (hit_pulse),
      .flag_o  (hit_flag)
   );

endmodule

// File: rtl/rxm_checker.sv
module rxm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       word_vld,
   input logic       frame_sof,
   input logic [2:0] match_mode,
   input logic       flag_clr,
   input logic       hit_pulse,
   input logic       hit_flag
);

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && (match_mode inside {3'b000, 3'b001})) |=> !hit_pulse); // R2

   AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && !frame_sof && (match_mode inside {3'b010, 3'b110})) |=> !hit_pulse); // R3 R7 R1

   AST_PULSE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pulse |-> $past(word_vld)); // R10

   AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pulse |=> hit_flag); // R11

   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_flag && flag_clr && !hit_pulse) |=> !hit_flag); // R11

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_flag && !flag_clr) |=> hit_flag); // R11

endmodule

bind rx_word_matcher rxm_checker i_rxm_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_vld   (word_vld),
   .frame_sof  (frame_sof),
   .match_mode (match_mode),
   .flag_clr   (flag_clr),
   .hit_pulse  (hit_pulse),
   .hit_flag   (hit_flag)
);

// File: tb/test_rx_word_matcher.sv
module test_rx_word_matcher;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       word_vld = 1'b0;
   logic       frame_sof = 1'b0;
   logic [7:0] word_data = '0;
   logic [2:0] match_mode = '0;
   logic [7:0] ref_a = '0;
   logic [7:0] ref_b = '0;
   logic       flag_clr = 1'b0;
   logic       hit_pulse;
   logic       hit_flag;

   always #10 clk = ~clk;

   rx_word_matcher #(.DATA_W(8)) i_rx_word_matcher (
      .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .frame_sof(frame_sof),
      .word_data(word_data), .match_mode(match_mode), .ref_a(ref_a),
      .ref_b(ref_b), .flag_clr(flag_clr), .hit_pulse(hit_pulse), .hit_flag(hit_flag)
   );

   typedef struct {
      logic  p;
      logic  f;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad   = 0;

   // reference model state
   int   m_idx = 2;
   logic m_first_a = 1'b0;
   logic m_armed = 1'b0;
   logic m_last_p = 1'b0;
   logic m_flag = 1'b0;

   task automatic check(input logic ok, input string tag, input logic act, input logic expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic logic model_hit(input logic s, input logic [7:0] d);
      int   i;
      logic arm, ea, eb, em, h;
      i   = s ? 0 : m_idx;
      arm = s ? 1'b0 : m_armed;
      ea  = (d == ref_a);
      eb  = (d == ref_b);
      em  = ((d & ref_b) == (ref_a & ref_b));
      case (match_mode)
         3'b010:  h = (i == 0) && (ea || eb);
         3'b011:  h = ea || eb;
         3'b100:  h = (i == 1) && m_first_a && eb;
         3'b101:  h = arm && eb;
         3'b110:  h = (i == 0) && em;
         3'b111:  h = em;
         default: h = 1'b0;
      endcase
      if (i == 0) m_first_a = ea;
      m_armed = ea;
      m_idx   = (i >= 2) ? 2 : i + 1;
      return h;
   endfunction

   // driver: one cycle of stimulus, one expected entry
   task automatic cyc(input logic v, input logic s, input logic [7:0] d,
                      input logic c, input string tag);
      exp_t e;
      logic p;
      @(negedge clk);
      word_vld  = v;
      frame_sof = s;
      word_data = d;
      flag_clr  = c;
      m_flag    = m_last_p | (m_flag & ~c);
      p         = v ? model_hit(s, d) : 1'b0;
      m_last_p  = p;
      e.p = p;
      e.f = m_flag;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wrd(input logic s, input logic [7:0] d, input string tag);
      cyc(1'b1, s, d, 1'b0, tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 8'h00, 1'b0, tag);
   endtask

   task automatic clear_flag();
      idle(2, "R11");
      cyc(1'b0, 1'b0, 8'h00, 1'b1, "R11");
      idle(1, "R11");
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(hit_pulse === e.p, {e.tag, " pulse"}, hit_pulse, e.p);
            check(hit_flag === e.f, "R11 flag", hit_flag, e.f);
         end
      end
   end

   // watchdog
   initial begin
      #(20 * 20000);
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      ref_a = 8'h5A;
      ref_b = 8'hC3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #5;
      check(hit_pulse === 1'b0, "R1 reset pulse", hit_pulse, 1'b0);
      check(hit_flag === 1'b0, "R1 reset flag", hit_flag, 1'b0);

      // R1: opening word not marked -> first-word rule does not fire
      match_mode = 3'b010;
      wrd(1'b0, 8'h5A, "R1");
      idle(2, "R1");

      // R2: disabled and reserved
      match_mode = 3'b000;
      wrd(1'b1, 8'h5A, "R2"); wrd(1'b0, 8'hC3, "R2");
      match_mode = 3'b001;
      wrd(1'b1, 8'h5A, "R2"); wrd(1'b0, 8'hC3, "R2");
      idle(2, "R2");

      // R3: first word equals either reference
      match_mode = 3'b010;
      wrd(1'b1, 8'h5A, "R3"); wrd(1'b0, 8'h5A, "R3");
      wrd(1'b1, 8'hC3, "R3"); wrd(1'b1, 8'h11, "R3");
      clear_flag();

      // R4: any word
      match_mode = 3'b011;
      wrd(1'b1, 8'h11, "R4"); wrd(1'b0, 8'h5A, "R4");
      wrd(1'b0, 8'h22, "R4"); wrd(1'b0, 8'hC3, "R4"); wrd(1'b0, 8'hC3, "R4");
      clear_flag();

      // R5: first A then second B
      match_mode = 3'b100;
      wrd(1'b1, 8'h5A, "R5"); wrd(1'b0, 8'hC3, "R5");
      wrd(1'b1, 8'h5A, "R5"); wrd(1'b0, 8'h5A, "R5"); wrd(1'b0, 8'hC3, "R5");
      wrd(1'b1, 8'h11, "R5"); wrd(1'b0, 8'hC3, "R5");
      clear_flag();

      // R6: any A then B, re-arm and disarm
      match_mode = 3'b101;
      wrd(1'b1, 8'h11, "R6"); wrd(1'b0, 8'h5A, "R6"); wrd(1'b0, 8'hC3, "R6");
      wrd(1'b0, 8'h5A, "R6"); wrd(1'b0, 8'h5A, "R6"); wrd(1'b0, 8'hC3, "R6");
      wrd(1'b0, 8'h5A, "R6"); wrd(1'b0, 8'h77, "R6"); wrd(1'b0, 8'hC3, "R6");
      // R9: a pending A does not cross a frame boundary
      wrd(1'b0, 8'h5A, "R9"); wrd(1'b1, 8'hC3, "R9");
      clear_flag();

      // R9: new frame restarts the position count for the pair rule
      match_mode = 3'b100;
      wrd(1'b1, 8'h5A, "R9"); wrd(1'b1, 8'h5A, "R9"); wrd(1'b0, 8'hC3, "R9");
      clear_flag();

      // R7: masked first word
      ref_a = 8'h35;
      ref_b = 8'h0F;
      match_mode = 3'b110;
      wrd(1'b1, 8'hA5, "R7"); wrd(1'b0, 8'h15, "R7"); wrd(1'b1, 8'hA4, "R7");
      clear_flag();

      // R8: masked any word
      match_mode = 3'b111;
      wrd(1'b1, 8'h00, "R8"); wrd(1'b0, 8'hF5, "R8");
      wrd(1'b0, 8'h36, "R8"); wrd(1'b0, 8'h05, "R8");
      idle(2, "R8");

      // R11: hold without clear, then set wins over a clear
      idle(3, "R11");
      wrd(1'b1, 8'h45, "R11");
      cyc(1'b0, 1'b0, 8'h00, 1'b1, "R11");
      idle(2, "R11");
      cyc(1'b0, 1'b0, 8'h00, 1'b1, "R11");
      idle(2, "R11");

      // R10: back-to-back hits produce separate single pulses
      wrd(1'b1, 8'h05, "R10"); idle(1, "R10"); wrd(1'b0, 8'h05, "R10");
      idle(3, "R10");

      wait (exp_q.size() == 0);
      #20;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule